// File: doc/BRIEF.md
# Contactless Pad Wrap and Leakage Test Chain

This block wraps every die pad, through-silicon connections included, in a bidirectional test cell and strings the cells into one serial chain that a TAP controller drives. In functional mode each cell is transparent: the core's output data and output enable reach the pad, and the pad's receiver feeds the core. With the mode bit set, each pad is driven from a pair of update latches loaded through the chain, and the core input is held at zero so that test values do not reach core logic.

Two contactless checks run through the TAP signals alone. In the wrap check, a pad drives a value and a TAP capture samples the same pad's receiver, so a broken driver or receiver path shows up in the shifted-out result. In the leakage check, a sequencer drives the latched values, lets them settle, releases every driver, waits a programmed number of TCK cycles and then captures the floating inputs. A pad that was driven low and holds low passes. A pad that drifts high shows excess leakage.

The serial path is paced by the TAP. One bit moves on each cycle with the shift enable high. There is no back-pressure, and the block can never stall the TAP. The sequencer start, wait count and done flag are plain control and status pins.

Top module: `pad_contactless_test`

## Requirements
- R1: After reset, the chain, both update latches of every cell and the done flag are 0. With test mode then set, every pad output and output enable reads 0.
- R2: While test_mode is 0, pad_out equals core_out, pad_oe equals core_oe and core_in equals pad_in, bit for bit.
- R3: While test_mode is 1, core_in is all zeros. While the sequencer is idle or done, pad i drives its data latch with its enable latch as output enable.
- R4: The chain is 2*NUM_PADS bits long. Bit 2i holds pad i's data and bit 2i+1 holds pad i's enable. scan_out shows bit 0. Each shift moves every bit one place toward bit 0 and loads scan_in into the top bit, so the first bit shifted in lands in bit 0.
- R5: Shifting never changes pad_out or pad_oe. Only an update pulse copies the chain into the latches.
- R6: A TAP capture loads each pad's receiver value into its data bit and the pad's current enable latch into its enable bit. A driven pad therefore reads back its own driven value.
- R7: seq_start is sampled at an edge in test mode from idle or done. In the next 2 cycles the pads are driven from the latches. In the following W+2 cycles every pad_oe is 0. The capture happens at the last of those edges, and seq_done is high from the cycle after.
- R8: W is seq_wait, sampled with the start. W=0 is legal and gives 2 floating cycles.
- R9: seq_done is 0 while a sequence runs and stays 1 after it until the next accepted start. A start is ignored while a sequence runs or while test_mode is 0.
- R10: Shift, capture and update requests from the TAP are ignored while a sequence runs.
- R11: Clearing test_mode aborts a running sequence and clears seq_done. A later start runs a full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock (TCK) |
| rst_n | input | 1 | Active-low reset |
| test_mode | input | 1 | 1 selects test drive of the pads, 0 selects functional pass-through |
| shift_en | input | 1 | Shift the chain one bit toward scan_out |
| capture_en | input | 1 | Capture pad receivers and enable latches into the chain |
| update_en | input | 1 | Copy the chain into the update latches |
| scan_in | input | 1 | Serial data into the chain |
| scan_out | output | 1 | Serial data out of the chain (bit 0) |
| seq_start | input | 1 | Start the leakage sequence |
| seq_wait | input | WAIT_W | Wait cycles between release and capture |
| seq_done | output | 1 | Leakage capture complete |
| core_out | input | NUM_PADS | Functional output data from the core |
| core_oe | input | NUM_PADS | Functional output enables from the core |
| core_in | output | NUM_PADS | Pad receiver values to the core |
| pad_out | output | NUM_PADS | Data to the pad drivers |
| pad_oe | output | NUM_PADS | Enables of the pad drivers |
| pad_in | input | NUM_PADS | Values from the pad receivers |

## Verification
The bench runs leakage sequences against a pad model that keeps a released low, lets a released high decay after a few cycles, and pulls selected pads high. Wait counts that land just before and just after each model threshold expose an off-by-one in the wait counter as a flipped captured bit and a wrong floating-cycle count. A zero wait checks that a counter which wrapped would hang or float far too long. A second start and a TAP update arrive mid-sequence. A design that accepted either would restart its timing or change the enables it hands back. Clearing the mode bit mid-sequence checks that done does not linger and that the next start still runs. The bench also checks that shifting alone leaves the pads untouched.

// File: rtl/pad_ct_pkg.sv
package pad_ct_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_DRIVE,
    SQ_SETTLE,
    SQ_RELEASE,
    SQ_WAIT,
    SQ_CAPTURE,
    SQ_DONE
  } leak_state_t;
endpackage

// File: rtl/pad_ct_cell.sv
// One bidirectional test cell: two shift bits, two update latches, pad mux.
module pad_ct_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  input  logic shift_en,
  input  logic tap_capture,
  input  logic seq_capture,
  input  logic update_en,
  input  logic release_en,
  input  logic scan_si,
  output logic scan_so,
  input  logic core_do,
  input  logic core_de,
  output logic core_di,
  output logic pad_do,
  output logic pad_de,
  input  logic pad_di
);
  logic sh_data, sh_en;
  logic lat_data, lat_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_data  <= 1'b0;
      sh_en    <= 1'b0;
      lat_data <= 1'b0;
      lat_en   <= 1'b0;
    end else begin
      if (seq_capture || tap_capture) begin
        sh_data <= pad_di;
        sh_en   <= lat_en;
      end else if (shift_en) begin
        sh_en   <= scan_si;
        sh_data <= sh_en;
      end
      if (update_en) begin
        lat_data <= sh_data;
        lat_en   <= sh_en;
      end
    end
  end

  assign scan_so = sh_data;
  assign pad_do  = test_mode ? lat_data : core_do;
  assign pad_de  = test_mode ? (lat_en & ~release_en) : core_de;
  assign core_di = test_mode ? 1'b0 : pad_di;
endmodule

// File: rtl/pad_ct_seq.sv
// Drive / settle / release / wait / capture sequencer for the leakage check.
module pad_ct_seq #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_cyc,
  output logic              release_en,
  output logic              capture_now,
  output logic              busy,
  output logic              done
);
  import pad_ct_pkg::*;

  leak_state_t       st;
  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] wait_lat;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      wait_lat <= '0;
      done_q   <= 1'b0;
    end else if (!test_mode) begin
      st     <= SQ_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE, SQ_DONE: begin
          if (start) begin
            st       <= SQ_DRIVE;
            wait_lat <= wait_cyc;
            done_q   <= 1'b0;
          end
        end
        SQ_DRIVE:  st <= SQ_SETTLE;
        SQ_SETTLE: st <= SQ_RELEASE;
        SQ_RELEASE: begin
          cnt <= wait_lat;
          st  <= (wait_lat == '0) ? SQ_CAPTURE : SQ_WAIT;
        end
        SQ_WAIT: begin
          if (cnt == WAIT_W'(1)) st <= SQ_CAPTURE;
          else cnt <= cnt - WAIT_W'(1);
        end
        SQ_CAPTURE: begin
          st     <= SQ_DONE;
          done_q <= 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign release_en  = (st == SQ_RELEASE) || (st == SQ_WAIT) || (st == SQ_CAPTURE);
  assign capture_now = (st == SQ_CAPTURE);
  assign busy        = (st != SQ_IDLE) && (st != SQ_DONE);
  assign done        = done_q;
endmodule

// File: rtl/pad_contactless_test.sv
module pad_contactless_test #(
  parameter int NUM_PADS = 4,
  parameter int WAIT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_mode,
  input  logic                shift_en,
  input  logic                capture_en,
  input  logic                update_en,
  input  logic                scan_in,
  output logic                scan_out,
  input  logic                seq_start,
  input  logic [WAIT_W-1:0]   seq_wait,
  output logic                seq_done,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] core_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  input  logic [NUM_PADS-1:0] pad_in
);
  logic              busy;
  logic              float_en;
  logic              seq_cap;
  logic              tap_shift, tap_cap, tap_upd;
  logic [NUM_PADS:0] link;

  pad_ct_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_mode  (test_mode),
    .start      (seq_start),
    .wait_cyc   (seq_wait),
    .release_en (float_en),
    .capture_now(seq_cap),
    .busy       (busy),
    .done       (seq_done)
  );

  assign tap_shift = shift_en   & ~busy;
  assign tap_cap   = capture_en & ~busy;
  assign tap_upd   = update_en  & ~busy;

  assign link[NUM_PADS] = scan_in;
  assign scan_out       = link[0];

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_cell
    pad_ct_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .test_mode  (test_mode),
      .shift_en   (tap_shift),
      .tap_capture(tap_cap),
      .seq_capture(seq_cap),
      .update_en  (tap_upd),
      .release_en (float_en),
      .scan_si    (link[i+1]),
      .scan_so    (link[i]),
      .core_do    (core_out[i]),
      .core_de    (core_oe[i]),
      .core_di    (core_in[i]),
      .pad_do     (pad_out[i]),
      .pad_de     (pad_oe[i]),
      .pad_di     (pad_in[i])
    );
  end
endmodule

// File: rtl/pad_contactless_test_chk.sv
module pad_contactless_test_chk #(
  parameter int NUM_PADS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                test_mode,
  input logic                update_en,
  input logic [NUM_PADS-1:0] core_out,
  input logic [NUM_PADS-1:0] core_oe,
  input logic [NUM_PADS-1:0] core_in,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] pad_in,
  input logic                seq_done,
  input logic                busy,
  input logic                float_en
);
  AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (pad_out == core_out && pad_oe == core_oe && core_in == pad_in)); // R2

  AST_CORE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> core_in == '0); // R3

  AST_PAD_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !update_en) |=> (!test_mode || $stable(pad_out))); // R5

  AST_RELEASE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    float_en |-> pad_oe == '0); // R7

  AST_CAPTURE_FLOATING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(pad_oe) == '0); // R7

  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !seq_done); // R9

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> !seq_done); // R11
endmodule

bind pad_contactless_test pad_contactless_test_chk #(.NUM_PADS(NUM_PADS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .test_mode(test_mode),
  .update_en(update_en),
  .core_out (core_out),
  .core_oe  (core_oe),
  .core_in  (core_in),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .pad_in   (pad_in),
  .seq_done (seq_done),
  .busy     (busy),
  .float_en (float_en)
);

// File: tb/sim_pad_contactless_test.sv
`timescale 1ns/1ps
module sim_pad_contactless_test;
  localparam int NP      = 4;
  localparam int WW      = 8;
  localparam int DECAY_T = 6;
  localparam int LEAK_T  = 3;

  // {data[19:16], wait[15:8], leak mask[7:4], expected capture[3:0]}
  localparam logic [19:0] VTAB [7] = '{
    {4'h0, 8'd5, 4'h0, 4'h0},
    {4'h0, 8'd5, 4'h5, 4'h5},
    {4'h0, 8'd1, 4'hF, 4'h0},
    {4'hF, 8'd5, 4'h0, 4'h0},
    {4'hF, 8'd3, 4'h0, 4'hF},
    {4'hA, 8'd2, 4'h6, 4'hE},
    {4'h3, 8'd0, 4'h8, 4'h3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
  logic scan_in = 1'b0, seq_start = 1'b0;
  logic scan_out, seq_done;
  logic [WW-1:0] seq_wait = '0;
  logic [NP-1:0] core_out = '0, core_oe = '0;
  logic [NP-1:0] core_in, pad_out, pad_oe, pad_in;

  logic [NP-1:0] held = '0;
  int            fcnt [NP];
  logic [NP-1:0] leak_mask = '0;

  int nchk = 0, nerr = 0, cyc = 0;
  logic wd_fired = 1'b0;

  always #2.5 clk = ~clk;

  pad_contactless_test #(.NUM_PADS(NP), .WAIT_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .scan_in(scan_in),
    .scan_out(scan_out), .seq_start(seq_start), .seq_wait(seq_wait),
    .seq_done(seq_done), .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  // Pad retention model: driven value held when released; a high decays
  // after DECAY_T floating cycles; a leaky pad is pulled high after LEAK_T.
  initial for (int i = 0; i < NP; i++) fcnt[i] = 0;
  always @(posedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (pad_oe[i]) begin
        held[i] <= pad_out[i];
        fcnt[i] <= 0;
      end else if (fcnt[i] < 1000) begin
        fcnt[i] <= fcnt[i] + 1;
      end
    end
  end
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      if (pad_oe[i]) pad_in[i] = pad_out[i];
      else if (leak_mask[i]) pad_in[i] = (fcnt[i] >= LEAK_T) ? 1'b1 : held[i];
      else pad_in[i] = (fcnt[i] >= DECAY_T) ? 1'b0 : held[i];
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !wd_fired) begin
      wd_fired = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*NP-1:0] mkvec(input logic [NP-1:0] d, input logic [NP-1:0] e);
    logic [2*NP-1:0] v;
    for (int i = 0; i < NP; i++) begin
      v[2*i]   = d[i];
      v[2*i+1] = e[i];
    end
    return v;
  endfunction

  task automatic shift_vec(input logic [2*NP-1:0] din, output logic [2*NP-1:0] dout);
    dout = '0;
    for (int k = 0; k < 2*NP; k++) begin
      @(negedge clk);
      dout[k]  = scan_out;
      scan_in  = din[k];
      shift_en = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); update_en = 1'b1;
    @(posedge clk);
    @(negedge clk); update_en = 1'b0;
  endtask

  task automatic pulse_cap();
    @(negedge clk); capture_en = 1'b1;
    @(posedge clk);
    @(negedge clk); capture_en = 1'b0;
  endtask

  task automatic run_seq(input int w, input logic [NP-1:0] exp_oe, input int poke_t,
                         input int upd_t, output int t_done, output int n_float,
                         output int n_drive);
    int t;
    n_float = 0;
    n_drive = 0;
    @(negedge clk);
    seq_wait  = WW'(w);
    seq_start = 1'b1;
    @(posedge clk);
    for (t = 1; t < 300; t++) begin
      @(negedge clk);
      seq_start = (t == poke_t);
      update_en = (t == upd_t);
      if (t == 1) chk("R9 done low once started", 32'(seq_done), 32'd0);
      if (seq_done) break;
      if (pad_oe == '0) n_float++;
      if (t <= 2 && pad_oe == exp_oe) n_drive++;
      @(posedge clk);
    end
    seq_start = 1'b0;
    update_en = 1'b0;
    t_done = t;
  endtask

  initial begin
    logic [2*NP-1:0] got;
    int td, nf, nd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 done after reset", 32'(seq_done), 32'd0);
    test_mode = 1'b1;
    @(negedge clk);
    chk("R1 pad_oe after reset", 32'(pad_oe), 32'd0);
    chk("R1 pad_out after reset", 32'(pad_out), 32'd0);
    shift_vec('0, got);
    chk("R1 chain after reset", 32'(got), 32'd0);

    // R2: functional pass-through
    test_mode = 1'b0;
    core_out = 4'b1010;
    core_oe  = 4'b0011;
    @(negedge clk);
    chk("R2 pad_out", 32'(pad_out), 32'hA);
    chk("R2 pad_oe", 32'(pad_oe), 32'h3);
    chk("R2 core_in from driven pads", 32'(core_in[1:0]), 32'h2);
    core_oe = '0;

    // R4: chain order, first in lands in bit 0
    test_mode = 1'b1;
    shift_vec(8'hC5, got);
    shift_vec(8'h00, got);
    chk("R4 chain round trip", 32'(got), 32'hC5);

    // R3, R5: latch load and shift isolation
    shift_vec(mkvec(4'b0110, 4'hF), got);
    pulse_upd();
    chk("R3 pad_out from data latches", 32'(pad_out), 32'h6);
    chk("R3 pad_oe from enable latches", 32'(pad_oe), 32'hF);
    chk("R3 core_in isolated", 32'(core_in), 32'd0);
    shift_vec(mkvec(4'b1001, 4'h0), got);
    chk("R5 pad_out unchanged by shift", 32'(pad_out), 32'h6);
    chk("R5 pad_oe unchanged by shift", 32'(pad_oe), 32'hF);
    pulse_upd();
    chk("R5 update applies new data", 32'(pad_out), 32'h9);

    // R6: wrap capture
    shift_vec(mkvec(4'b0110, 4'hF), got);
    pulse_upd();
    pulse_cap();
    shift_vec('0, got);
    chk("R6 wrap readback", 32'(got), 32'(mkvec(4'b0110, 4'hF)));

    // R7, R8: leakage vectors
    for (int v = 0; v < 7; v++) begin
      logic [3:0] d, lk, ex;
      int w;
      d  = VTAB[v][19:16];
      w  = int'(VTAB[v][15:8]);
      lk = VTAB[v][7:4];
      ex = VTAB[v][3:0];
      leak_mask = lk;
      shift_vec(mkvec(d, 4'hF), got);
      pulse_upd();
      run_seq(w, 4'hF, 0, 0, td, nf, nd);
      chk("R7 drive cycles", 32'(nd), 32'd2);
      chk("R7 R8 floating cycles", 32'(nf), 32'(w + 2));
      chk("R8 done timing", 32'(td), 32'(w + 5));
      shift_vec('0, got);
      chk("R7 leakage capture", 32'(got), 32'(mkvec(ex, 4'hF)));
    end
    leak_mask = '0;

    // R9: done holds; restart while busy ignored
    repeat (4) @(negedge clk);
    chk("R9 done holds", 32'(seq_done), 32'd1);
    shift_vec(mkvec(4'b0000, 4'hF), got);
    pulse_upd();
    run_seq(3, 4'hF, 2, 0, td, nf, nd);
    chk("R9 restart while busy ignored", 32'(td), 32'd8);

    // R10: update while busy ignored
    shift_vec(mkvec(4'b1111, 4'h0), got);
    run_seq(4, 4'hF, 0, 5, td, nf, nd);
    chk("R10 done timing with TAP update", 32'(td), 32'd9);
    chk("R10 enables kept", 32'(pad_oe), 32'hF);

    // R11: abort by clearing test mode
    @(negedge clk);
    seq_wait = 8'd20; seq_start = 1'b1;
    @(posedge clk);
    @(negedge clk); seq_start = 1'b0;
    repeat (5) @(negedge clk);
    test_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 done cleared by abort", 32'(seq_done), 32'd0);
    test_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 idle after abort", 32'(pad_oe), 32'hF);
    run_seq(2, 4'hF, 0, 0, td, nf, nd);
    chk("R11 full run after abort", 32'(td), 32'd7);

    // R9: start ignored outside test mode
    test_mode = 1'b0;
    @(negedge clk); seq_start = 1'b1;
    @(negedge clk); seq_start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 start ignored in functional mode", 32'(seq_done), 32'd0);
    test_mode = 1'b1;
    @(negedge clk);
    chk("R9 no sequence started", 32'(pad_oe), 32'hF);

    summary();
    $finish;
  end
endmodule